// File: doc/BRIEF.md
# Reference Clock Source Enable Controller

This block holds the software-visible settings that decide which reference clocks of a clock generator run. It also decides which of them stay alive while the chip is in stop mode. There are two references: an internal one and an external one. For each, the block drives an output clock-gate enable and a keep-alive enable. It also tells the frequency-locked loop whether to run and whether to take its reference from the external source. A bus divider select is held here and passed straight to the divider.

Firmware writes two byte-wide registers. Some write rules are enforced in hardware:
- The source-select bit cannot change while the low-power bit is set.
- The trim field survives every reset except power-on.

The keep-alive outputs combine these register bits with the stop-mode input and the current operating-mode code. The code comes from the clock generator's mode logic.

Top module: `clk_src_ctrl`

## Requirements
- R1: After power-on reset, the control register (address 0) reads 0x42: low-power 0, source-select 1 (internal), all enables 0, bus divider 1. The trim register (address 1) reads 0x80. The control layout is bit 0 low-power, bit 1 source-select (1 = internal), bit 2 internal enable, bit 3 internal stop-enable, bit 4 external enable, bit 5 external stop-enable, bits 7:6 bus divider.
- R2: A control write leaves the source-select bit unchanged when the stored low-power bit is 1 before the write. This holds even when the same write clears low-power. Such a write raises no error, and its other fields are still written.
- R3: `loop_en_o` is 1 when low-power is 0. It is also 1 when the mode code is an engaged mode: 0 (loop, internal ref), 1 (loop, external ref) or 4 (PLL, external ref). It is 0 only when low-power is 1 and the mode is one of the bypass codes 2, 3, 5, 6 or 7.
- R4: `irc_gate_o` equals the internal enable bit. In stop mode, `irc_keep_o` is 1 only when both the internal enable and the internal stop-enable bits are 1.
- R5: In stop mode, `erc_keep_o` is 1 when the external enable and external stop-enable bits are both 1. It is also 1 when the mode code is an external-reference mode: 1, 3, 4, 5 or 7.
- R6: Outside stop mode, `irc_keep_o` follows the internal enable bit, and `erc_keep_o` follows the external enable bit.
- R7: `loop_ref_ext_o` is 0 while source-select is 1 (internal). In that case the external reference reaches only `erc_gate_o`, which follows the external enable bit.
- R8: The trim register is loaded by writes to address 1. It keeps its value through `rst_ni`, and returns to 0x80 only on `por_ni`. `rst_ni` returns the control register to its reset value.
- R9: `bdiv_o` shows a newly written divider value on the clock edge that takes the write, with no extra delay.
- R10: A read of address 0 or 1 returns the whole register through `rd_data_o` combinationally. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | General reset, active low, asynchronous |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 trim) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data |
| stop_i | input | 1 | Chip is in stop mode |
| mode_i | input | 3 | Current operating-mode code |
| irc_gate_o | output | 1 | Internal reference output gate enable |
| erc_gate_o | output | 1 | External reference output gate enable |
| irc_keep_o | output | 1 | Internal reference keep-alive |
| erc_keep_o | output | 1 | External reference keep-alive |
| loop_en_o | output | 1 | Loop oscillator enable |
| loop_ref_ext_o | output | 1 | Route external reference to the loop |
| bdiv_o | output | 2 | Bus divider select |

## Verification
The hardest case to reach is a control write that clears low-power and tries to flip source-select in the same cycle. The blocking must use the stored low-power bit, not the incoming one. The bench reaches it by first writing low-power with the internal source, then issuing that combined write. It then issues the same write again, now accepted, and checks both results through a register read and `loop_ref_ext_o`. The external keep-alive is swept across all eight mode codes while `stop_i` is held high, with the enable pair cleared. This shows that the mode code alone can hold the reference alive.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int MODE_W   = 3;
  localparam int BDIV_W   = 2;
  localparam int TRIM_W   = 8;
  localparam int BDIV_LSB = 6;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TRIM = 2'd1;

  typedef struct packed {
    logic [BDIV_W-1:0] bdiv;
    logic              erc_sten;
    logic              erc_en;
    logic              irc_sten;
    logic              irc_en;
    logic              src_int;
    logic              low_power;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RST = '{bdiv: 2'd1, erc_sten: 1'b0, erc_en: 1'b0,
                                 irc_sten: 1'b0, irc_en: 1'b0, src_int: 1'b1,
                                 low_power: 1'b0};
  localparam logic [TRIM_W-1:0] TRIM_RST = 8'h80;
endpackage

// File: rtl/ccs_regfile.sv
module ccs_regfile
  import ccs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output ctrl_t             ctrl_o,
  output logic [TRIM_W-1:0] trim_o
);
  ctrl_t             ctrl_q, ctrl_d, wr_ctrl;
  logic [TRIM_W-1:0] trim_q;
  logic              any_rst_n;
  logic              wr_ctrl_en, wr_trim_en;

  assign any_rst_n  = rst_ni & por_ni;
  assign wr_ctrl_en = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_trim_en = wr_en_i && (wr_addr_i == ADDR_TRIM);
  assign wr_ctrl    = ctrl_t'(wr_data_i[CTRL_W-1:0]);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl_en) begin
      ctrl_d = wr_ctrl;
      // source select frozen by the stored low-power bit
      if (ctrl_q.low_power) ctrl_d.src_int = ctrl_q.src_int;
    end
  end

  always_ff @(posedge clk_i or negedge any_rst_n) begin
    if (!any_rst_n) ctrl_q <= CTRL_RST;
    else            ctrl_q <= ctrl_d;
  end

  // trim survives general reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)         trim_q <= TRIM_RST;
    else if (wr_trim_en) trim_q <= wr_data_i[TRIM_W-1:0];
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL: rd_data_o = DATA_W'(ctrl_q);
      ADDR_TRIM: rd_data_o = DATA_W'(trim_q);
      default:   rd_data_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign trim_o = trim_q;
endmodule

// File: rtl/ccs_mode_decode.sv
module ccs_mode_decode
  import ccs_pkg::*;
#(
  parameter logic [MODE_W-1:0] MODE_LOOP_INT   = 3'd0,
  parameter logic [MODE_W-1:0] MODE_LOOP_EXT   = 3'd1,
  parameter logic [MODE_W-1:0] MODE_BYP_INT    = 3'd2,
  parameter logic [MODE_W-1:0] MODE_BYP_EXT    = 3'd3,
  parameter logic [MODE_W-1:0] MODE_PLL_EXT    = 3'd4,
  parameter logic [MODE_W-1:0] MODE_PLLBYP_EXT = 3'd5,
  parameter logic [MODE_W-1:0] MODE_LPBYP_INT  = 3'd6,
  parameter logic [MODE_W-1:0] MODE_LPBYP_EXT  = 3'd7
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic              ext_mode_o,
  output logic              engaged_o
);
  localparam int N_MODES = 8;
  localparam logic [MODE_W-1:0] CODES [N_MODES] = '{
    MODE_LOOP_INT, MODE_LOOP_EXT, MODE_BYP_INT, MODE_BYP_EXT,
    MODE_PLL_EXT, MODE_PLLBYP_EXT, MODE_LPBYP_INT, MODE_LPBYP_EXT};
  localparam logic [N_MODES-1:0] EXT_MASK = 8'b1011_1010;
  localparam logic [N_MODES-1:0] ENG_MASK = 8'b0001_0011;

  logic [N_MODES-1:0] hit;

  for (genvar i = 0; i < N_MODES; i++) begin : g_hit
    assign hit[i] = (mode_i == CODES[i]);
  end

  assign ext_mode_o = |(hit & EXT_MASK);
  assign engaged_o  = |(hit & ENG_MASK);
endmodule

// File: rtl/ccs_ref_keep.sv
module ccs_ref_keep (
  input  logic en_i,
  input  logic sten_i,
  input  logic mode_hold_i,
  input  logic stop_i,
  output logic gate_o,
  output logic keep_o
);
  assign gate_o = en_i;
  assign keep_o = stop_i ? ((en_i & sten_i) | mode_hold_i) : en_i;
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import ccs_pkg::*;
#(
  parameter logic [MODE_W-1:0] MODE_LOOP_INT   = 3'd0,
  parameter logic [MODE_W-1:0] MODE_LOOP_EXT   = 3'd1,
  parameter logic [MODE_W-1:0] MODE_BYP_INT    = 3'd2,
  parameter logic [MODE_W-1:0] MODE_BYP_EXT    = 3'd3,
  parameter logic [MODE_W-1:0] MODE_PLL_EXT    = 3'd4,
  parameter logic [MODE_W-1:0] MODE_PLLBYP_EXT = 3'd5,
  parameter logic [MODE_W-1:0] MODE_LPBYP_INT  = 3'd6,
  parameter logic [MODE_W-1:0] MODE_LPBYP_EXT  = 3'd7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              stop_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              irc_gate_o,
  output logic              erc_gate_o,
  output logic              irc_keep_o,
  output logic              erc_keep_o,
  output logic              loop_en_o,
  output logic              loop_ref_ext_o,
  output logic [BDIV_W-1:0] bdiv_o
);
  ctrl_t             ctrl;
  logic [TRIM_W-1:0] trim_unused;
  logic              ext_mode, engaged;
  logic [1:0]        ref_en, ref_sten, ref_hold, ref_gate, ref_keep;

  ccs_regfile u_regs (
    .clk_i, .rst_ni, .por_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .ctrl_o(ctrl), .trim_o(trim_unused)
  );

  ccs_mode_decode #(
    .MODE_LOOP_INT(MODE_LOOP_INT), .MODE_LOOP_EXT(MODE_LOOP_EXT),
    .MODE_BYP_INT(MODE_BYP_INT),   .MODE_BYP_EXT(MODE_BYP_EXT),
    .MODE_PLL_EXT(MODE_PLL_EXT),   .MODE_PLLBYP_EXT(MODE_PLLBYP_EXT),
    .MODE_LPBYP_INT(MODE_LPBYP_INT), .MODE_LPBYP_EXT(MODE_LPBYP_EXT)
  ) u_mode (
    .mode_i, .ext_mode_o(ext_mode), .engaged_o(engaged)
  );

  // index 0 internal, 1 external
  assign ref_en   = {ctrl.erc_en,   ctrl.irc_en};
  assign ref_sten = {ctrl.erc_sten, ctrl.irc_sten};
  assign ref_hold = {ext_mode,      1'b0};

  for (genvar r = 0; r < 2; r++) begin : g_ref
    ccs_ref_keep u_keep (
      .en_i(ref_en[r]), .sten_i(ref_sten[r]), .mode_hold_i(ref_hold[r]),
      .stop_i, .gate_o(ref_gate[r]), .keep_o(ref_keep[r])
    );
  end

  assign irc_gate_o     = ref_gate[0];
  assign erc_gate_o     = ref_gate[1];
  assign irc_keep_o     = ref_keep[0];
  assign erc_keep_o     = ref_keep[1];
  assign loop_en_o      = ~ctrl.low_power | engaged;
  assign loop_ref_ext_o = ~ctrl.src_int;
  assign bdiv_o         = ctrl.bdiv;

  // trim is exported only through the read port here
  logic trim_sink;
  assign trim_sink = ^trim_unused;
  logic unused_ok;
  assign unused_ok = trim_sink & 1'b0;
endmodule

// File: rtl/clk_src_ctrl_chk.sv
module clk_src_ctrl_chk
  import ccs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              wr_ctrl_i,
  input logic              wdata_lp_i,
  input logic [BDIV_W-1:0] wdata_bdiv_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              stop_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              irc_gate_i,
  input logic              erc_gate_i,
  input logic              irc_keep_i,
  input logic              erc_keep_i,
  input logic              loop_en_i,
  input logic              loop_ref_ext_i,
  input logic [BDIV_W-1:0] bdiv_i
);
  logic rst_n;
  logic ext_code;
  assign rst_n    = rst_ni & por_ni;
  assign ext_code = (mode_i == 3'd1) || (mode_i == 3'd3) || (mode_i == 3'd4) ||
                    (mode_i == 3'd5) || (mode_i == 3'd7);

  AST_SRC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_ctrl_i && !loop_en_i && wdata_lp_i) |=> $stable(loop_ref_ext_i)); // R2

  AST_IRC_STOP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stop_i && !irc_gate_i) |-> !irc_keep_i); // R4

  AST_ERC_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (stop_i && ext_code) |-> erc_keep_i); // R5

  AST_RUN_FOLLOWS_EN: assert property (@(posedge clk_i) disable iff (!rst_n)
    !stop_i |-> (irc_keep_i == irc_gate_i) && (erc_keep_i == erc_gate_i)); // R6

  AST_BDIV_NEXT: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_ctrl_i |=> (bdiv_i == $past(wdata_bdiv_i))); // R9

  AST_BDIV_READBACK: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_addr_i == ADDR_CTRL) |-> (rd_data_i[BDIV_LSB +: BDIV_W] == bdiv_i)); // R10
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni),
  .wr_ctrl_i(wr_en_i && (wr_addr_i == ccs_pkg::ADDR_CTRL)),
  .wdata_lp_i(wr_data_i[0]),
  .wdata_bdiv_i(wr_data_i[ccs_pkg::BDIV_LSB +: ccs_pkg::BDIV_W]),
  .rd_data_i(rd_data_o), .rd_addr_i(rd_addr_i),
  .stop_i(stop_i), .mode_i(mode_i),
  .irc_gate_i(irc_gate_o), .erc_gate_i(erc_gate_o),
  .irc_keep_i(irc_keep_o), .erc_keep_i(erc_keep_o),
  .loop_en_i(loop_en_o), .loop_ref_ext_i(loop_ref_ext_o), .bdiv_i(bdiv_o)
);

// File: tb/clk_src_ctrl_test.sv
`timescale 1ns/1ps
module clk_src_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0, por_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       stop_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic       irc_gate_o, erc_gate_o, irc_keep_o, erc_keep_o, loop_en_o, loop_ref_ext_o;
  logic [1:0] bdiv_o;
  int         n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  clk_src_ctrl uut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr_i = a; #1;
    chk(req, rd_data_o, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 2'd0, 8'h42);
    rd_chk("R1 trim", 2'd1, 8'h80);
    chk("R1 bdiv", 8'(bdiv_o), 8'd1);
    chk("R1 gates", {6'd0, irc_gate_o, erc_gate_o}, 8'd0);
    chk("R7 route", 8'(loop_ref_ext_o), 8'd0);
    chk("R3 loop_en", 8'(loop_en_o), 8'd1);
    rd_chk("R10 unmapped", 2'd2, 8'h00);
    rd_chk("R10 unmapped", 2'd3, 8'h00);
  endtask

  task automatic t_trim;
    wr(2'd1, 8'h3C);
    wr(2'd0, 8'h5D);
    @(negedge clk_i); rst_ni = 1'b0; #1; rst_ni = 1'b1;
    rd_chk("R8 trim kept", 2'd1, 8'h3C);
    rd_chk("R8 ctrl reset", 2'd0, 8'h42);
    @(negedge clk_i); por_ni = 1'b0; #1; por_ni = 1'b1;
    rd_chk("R8 trim por", 2'd1, 8'h80);
  endtask

  task automatic t_src_block;
    wr(2'd0, 8'h43);
    wr(2'd0, 8'h41);
    rd_chk("R2 blocked", 2'd0, 8'h43);
    chk("R7 route int", 8'(loop_ref_ext_o), 8'd0);
    wr(2'd0, 8'h40);
    rd_chk("R2 lp clear still blocks", 2'd0, 8'h42);
    wr(2'd0, 8'h40);
    rd_chk("R2 accepted", 2'd0, 8'h40);
    chk("R7 route ext", 8'(loop_ref_ext_o), 8'd1);
  endtask

  task automatic t_loop_en;
    wr(2'd0, 8'h41);
    for (int m = 0; m < 8; m++) begin
      mode_i = 3'(m); #1;
      chk("R3 lp=1", 8'(loop_en_o), (m == 0 || m == 1 || m == 4) ? 8'd1 : 8'd0);
    end
    wr(2'd0, 8'h40);
    mode_i = 3'd7; #1;
    chk("R3 lp=0", 8'(loop_en_o), 8'd1);
    mode_i = 3'd0;
  endtask

  task automatic t_irc;
    wr(2'd0, 8'h46);
    stop_i = 1'b0; #1;
    chk("R6 irc run", {6'd0, irc_gate_o, irc_keep_o}, 8'd3);
    stop_i = 1'b1; #1;
    chk("R4 irc stop no sten", {6'd0, irc_gate_o, irc_keep_o}, 8'd2);
    wr(2'd0, 8'h4E);
    chk("R4 irc stop sten", 8'(irc_keep_o), 8'd1);
    stop_i = 1'b0;
  endtask

  task automatic t_erc;
    wr(2'd0, 8'h42);
    stop_i = 1'b1;
    for (int m = 0; m < 8; m++) begin
      mode_i = 3'(m); #1;
      chk("R5 mode hold", 8'(erc_keep_o),
          (m == 1 || m == 3 || m == 4 || m == 5 || m == 7) ? 8'd1 : 8'd0);
    end
    mode_i = 3'd0;
    wr(2'd0, 8'h52);
    chk("R5 en only stop", 8'(erc_keep_o), 8'd0);
    chk("R7 erc gate", {6'd0, erc_gate_o, loop_ref_ext_o}, 8'd2);
    wr(2'd0, 8'h72);
    chk("R5 en+sten stop", 8'(erc_keep_o), 8'd1);
    stop_i = 1'b0; mode_i = 3'd3;
    wr(2'd0, 8'h42);
    chk("R6 erc run follows en", 8'(erc_keep_o), 8'd0);
    mode_i = 3'd0;
  endtask

  task automatic t_bdiv;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'hC2;
    #1;
    chk("R9 before edge", 8'(bdiv_o), 8'd1);
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    chk("R9 after edge", 8'(bdiv_o), 8'd3);
    rd_chk("R10 ctrl read", 2'd0, 8'hC2);
  endtask

  initial begin
    #5; por_ni = 1'b1; rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_trim();
    t_src_block();
    t_loop_en();
    t_irc();
    t_erc();
    t_bdiv();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule